// File: doc/BRIEF.md
# Vector Address Set-Bit Sequencer

This block turns a packed vector address into a stream of one-hot byte-lane selects. During a partial configuration update, each set bit of the vector marks one byte lane of a frame data register that must be rewritten. The sequencer emits one select vector per set bit. Taken together, these selects XOR back to the original vector. Bits that are clear are skipped, so no cycles are spent on lanes that do not change.

A vector is loaded with a strobe while the sequencer is idle. On each following cycle in which the consumer raises the advance strobe, the sequencer emits the current one-hot select and then clears that bit from its internal vector register. When the register reaches zero, the done flag rises and the next vector may be loaded. A parameter chooses whether the highest-numbered or the lowest-numbered set bit is served first. The two variants are built by different select networks.

Top module: `vaddr_bit_sequencer`

## Requirements
- R1: After reset, done_o is 1, valid_o is 0 and sel_o is all zeros.
- R2: A load_i pulse while done_o is 1 captures vec_i. From the next cycle, valid_o is 1 exactly when the captured vector is nonzero.
- R3: While valid_o is 1, sel_o has exactly one bit set, and that bit is set in the stored vector. With ORDER = VBS_HIGH_FIRST (the default), it is the highest-numbered set bit. With ORDER = VBS_LOW_FIRST, it is the lowest-numbered set bit.
- R4: When adv_i is 1 while valid_o is 1, the selected bit is cleared from the stored vector at the clock edge. The XOR of all selects emitted for one load equals the loaded vector.
- R5: While valid_o is 1 and adv_i is 0, sel_o and valid_o hold their values.
- R6: done_o is 1 exactly when the stored vector is zero. valid_o is always the inverse of done_o, and sel_o is all zeros while done_o is 1.
- R7: Loading an all-zero vector leaves done_o at 1, with no select emitted.
- R8: A load_i pulse while done_o is 0 is ignored, and the vector in progress continues unchanged.
- R9: adv_i while done_o is 1 has no effect: done_o stays 1 and sel_o stays zero.
- R10: With adv_i held high, one select is emitted per cycle. A vector with k set bits drains in exactly k cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe; accepted only while done_o is 1 |
| vec_i | input | WIDTH | Vector address to sequence |
| adv_i | input | 1 | Advance strobe; consumes the current select |
| sel_o | output | WIDTH | Current one-hot lane select |
| valid_o | output | 1 | sel_o holds a select that has not been consumed |
| done_o | output | 1 | Stored vector is empty; ready for a new load |

## Verification
The assertions place no restriction on load_i or adv_i: a load while busy, an advance while idle, and both strobes in the same cycle are all legal. The properties state how each of these cases is resolved. They do assume that vec_i is a known value whenever load_i is accepted, and the stimulus always drives defined values on every input. The stimulus drives both order variants in lock step with the same vectors, including the all-ones, all-zero, single-end-bit and alternating patterns. This lets the two select networks be compared on identical set-bit populations.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

   // Order in which set bits of the vector are served.
   typedef enum logic {
      VBS_HIGH_FIRST = 1'b0,
      VBS_LOW_FIRST  = 1'b1
   } vbs_order_e;

endpackage

// File: rtl/vbs_select_net.sv
// Combinational network choosing one set bit of the stored vector.
module vbs_select_net #(
   parameter int                   WIDTH = 8,
   parameter vbs_pkg::vbs_order_e  ORDER = vbs_pkg::VBS_HIGH_FIRST
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic [WIDTH-1:0] sel_o
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (ORDER == vbs_pkg::VBS_HIGH_FIRST) begin : g_high
         // Prefix-OR mask from the top down; a lane is selected where the
         // mask first turns on, found by XOR of neighbouring mask bits.
         logic [WIDTH:0] mask;
         assign mask[WIDTH] = 1'b0;
         for (genvar j = WIDTH - 1; j >= 0; j--) begin : g_lane
            assign mask[j]  = mask[j+1] | vec_i[j];
            assign sel_o[j] = mask[j] ^ mask[j+1];
         end
      end else begin : g_low
         // Two's-complement isolation of the lowest set bit.
         assign sel_o = vec_i & (~vec_i + ONE);
      end
   endgenerate

endmodule

// File: rtl/vbs_vector_reg.sv
// Holds the vector still to be sequenced.
module vbs_vector_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             take_i,
   input  logic [WIDTH-1:0] take_val_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] clr_mask_i,
   output logic [WIDTH-1:0] vec_o
);

   logic [WIDTH-1:0] vec_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vec_q <= '0;
      end else if (take_i) begin
         vec_q <= take_val_i;
      end else if (clr_i) begin
         vec_q <= vec_q & ~clr_mask_i;
      end
   end

   assign vec_o = vec_q;

endmodule

// File: rtl/vbs_status.sv
// Empty detection on the stored vector.
module vbs_status #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             empty_o
);

   assign empty_o = ~|vec_i;

endmodule

// File: rtl/vaddr_bit_sequencer.sv
module vaddr_bit_sequencer #(
   parameter int                   WIDTH = 8,
   parameter vbs_pkg::vbs_order_e  ORDER = vbs_pkg::VBS_HIGH_FIRST
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] vec_i,
   input  logic             adv_i,
   output logic [WIDTH-1:0] sel_o,
   output logic             valid_o,
   output logic             done_o
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   initial begin
      assert (WIDTH >= 2) else $error("vaddr_bit_sequencer: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] vec_q;
   logic [WIDTH-1:0] pick;
   logic             empty;
   logic             take;
   logic             step;

   assign take = load_i & empty;
   assign step = adv_i & ~empty;

   vbs_vector_reg #(.WIDTH(WIDTH)) u_vreg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .take_val_i (vec_i),
      .clr_i      (step),
      .clr_mask_i (pick),
      .vec_o      (vec_q)
   );

   vbs_select_net #(.WIDTH(WIDTH), .ORDER(ORDER)) u_sel (
      .vec_i (vec_q),
      .sel_o (pick)
   );

   vbs_status #(.WIDTH(WIDTH)) u_stat (
      .vec_i   (vec_q),
      .empty_o (empty)
   );

   assign sel_o   = pick;
   assign done_o  = empty;
   assign valid_o = ~empty;

   // R2
   load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && done_o) |=> (vec_q == $past(vec_i)));

   // R3
   sel_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ($countones(sel_o) == 1));

   // R3
   sel_in_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((sel_o & ~vec_q) == '0));

   generate
      if (ORDER == vbs_pkg::VBS_HIGH_FIRST) begin : g_order_high
         // R3
         order_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_o |-> ((vec_q & ~(sel_o | (sel_o - ONE))) == '0));
      end else begin : g_order_low
         // R3
         order_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_o |-> ((vec_q & (sel_o - ONE)) == '0));
      end
   endgenerate

   // R4
   step_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && valid_o) |=> (vec_q == ($past(vec_q) & ~$past(sel_o))));

   // R5
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !adv_i) |=> ($stable(sel_o) && valid_o));

   // R6
   done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o != valid_o);

   // R6
   idle_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (sel_o == '0));

   // R8
   busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !done_o && !adv_i) |=> $stable(vec_q));

   // R9
   idle_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !load_i) |=> done_o);

   // R10
   one_per_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && valid_o) |=> ($countones(vec_q) == $countones($past(vec_q)) - 1));

endmodule

// File: tb/vaddr_bit_sequencer_bench.sv
module vaddr_bit_sequencer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [7:0] vec = 8'h00;
   logic       adv = 1'b0;
   logic [7:0] sel_h, sel_l;
   logic       valid_h, valid_l, done_h, done_l;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   vaddr_bit_sequencer #(.WIDTH(8), .ORDER(vbs_pkg::VBS_HIGH_FIRST)) u_vaddr_bit_sequencer (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .vec_i(vec), .adv_i(adv),
      .sel_o(sel_h), .valid_o(valid_h), .done_o(done_h)
   );

   vaddr_bit_sequencer #(.WIDTH(8), .ORDER(vbs_pkg::VBS_LOW_FIRST)) u_vaddr_bit_sequencer_low (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .vec_i(vec), .adv_i(adv),
      .sel_o(sel_l), .valid_o(valid_l), .done_o(done_l)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [7:0] pick_high(input logic [7:0] v);
      logic [7:0] r = 8'h00;
      for (int i = 0; i < 8; i++) if (v[i]) r = 8'h01 << i;
      return r;
   endfunction

   function automatic logic [7:0] pick_low(input logic [7:0] v);
      logic [7:0] r = 8'h00;
      for (int i = 7; i >= 0; i--) if (v[i]) r = 8'h01 << i;
      return r;
   endfunction

   function automatic int popc(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) if (v[i]) n++;
      return n;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      check("R1 done", done_h, 1);
      check("R1 valid", valid_h, 0);
      check("R1 sel", sel_h, 0);
      check("R1 done low", done_l, 1);
   endtask

   task automatic t_walk(input logic [7:0] v);
      logic [7:0] hv = v, lv = v, xh = 8'h00, xl = 8'h00;
      int steps = 0;
      load = 1'b1; vec = v; tick(); load = 1'b0;
      check("R2 valid after load", valid_h, (v != 8'h00));
      adv = 1'b1;
      while (hv != 8'h00 && steps < 16) begin
         check("R3 high-first sel", sel_h, pick_high(hv));
         check("R3 low-first sel", sel_l, pick_low(lv));
         xh ^= sel_h; xl ^= sel_l;
         hv &= ~pick_high(hv); lv &= ~pick_low(lv);
         steps++;
         tick();
      end
      adv = 1'b0;
      check("R4 xor high", xh, v);
      check("R4 xor low", xl, v);
      check("R10 cycles", steps, popc(v));
      check("R6 done high", done_h, 1);
      check("R6 done low", done_l, 1);
      check("R6 idle sel", sel_h, 0);
   endtask

   task automatic t_hold();
      logic [7:0] first;
      load = 1'b1; vec = 8'h4A; tick(); load = 1'b0;
      first = sel_h;
      check("R5 first sel", first, 8'h40);
      repeat (3) begin
         tick();
         check("R5 sel held", sel_h, first);
         check("R5 valid held", valid_h, 1);
      end
      adv = 1'b1;
      repeat (3) tick();
      adv = 1'b0;
      check("R6 drained", done_h, 1);
   endtask

   task automatic t_zero();
      load = 1'b1; vec = 8'h00; tick(); load = 1'b0;
      check("R7 done", done_h, 1);
      check("R7 valid", valid_h, 0);
      check("R7 sel", sel_h, 0);
   endtask

   task automatic t_busy_load();
      load = 1'b1; vec = 8'h81; tick();
      vec = 8'h3C; tick(); load = 1'b0;
      check("R8 sel unchanged", sel_h, 8'h80);
      check("R8 low sel unchanged", sel_l, 8'h01);
      adv = 1'b1; tick();
      check("R8 second sel", sel_h, 8'h01);
      tick(); adv = 1'b0;
      check("R8 done after old vector", done_h, 1);
   endtask

   task automatic t_idle_adv();
      adv = 1'b1;
      repeat (3) begin
         tick();
         check("R9 done", done_h, 1);
         check("R9 sel", sel_h, 0);
      end
      adv = 1'b0;
      load = 1'b1; vec = 8'h20; tick(); load = 1'b0;
      check("R9 load after idle adv", sel_h, 8'h20);
      adv = 1'b1; tick(); adv = 1'b0;
      check("R9 drained", done_h, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_walk(8'hFF);
      t_walk(8'h01);
      t_walk(8'h80);
      t_walk(8'hA5);
      t_walk(8'h5A);
      t_walk(8'h10);
      t_hold();
      t_zero();
      t_busy_load();
      t_idle_adv();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule